// File: doc/BRIEF.md
# Synthesizer Divider and Phase Detector

This block is the digital heart of a frequency-synthesis loop. Two dividers run side by side. One divides the reference timebase by a fixed 512. The other divides the prescaled oscillator signal by a programmable 15-bit ratio. A tri-state phase/frequency detector compares the falling edges of the two divided signals. It asks an external charge pump to source current (UP) or sink current (DOWN) for as long as the two edges are apart. When neither request is active, it marks the pump output as high-impedance.

Everything runs on one system clock. Each input signal arrives as a one-cycle tick strobe, so the reference tick occurs once per reference-clock period and the signal tick once per prescaled-input period. A force bit places the pump in high-impedance regardless of phase. A routing bit brings both divided waveforms out to two test pins. A current-select bit is passed straight through to the pump.

Top module: `synth_pll_core`

## Requirements
- R1: With `test_route_i`=1 and a reference tick on every clock, `tp_ref_o` is a divided waveform whose falling edges are exactly 512 ticks apart.
- R2: With `test_route_i`=1 and a signal tick on every clock, `tp_sig_o` falls once every N ticks, for any N from 256 to 32767 on `ratio_i`.
- R3: A ratio below 256 on `ratio_i` divides by 256.
- R4: A new `ratio_i` value is adopted only when the divider reaches its terminal count. The divided waveform is high while the count is below N/2 and low from N/2 to N-1, so a change made just after a falling edge gives one gap of (N_old - N_old/2 + N_new/2) ticks and N_new afterwards.
- R5: When the divided signal falls D cycles before the divided reference, `pump_up_o` is high for exactly D cycles per comparison and `pump_dn_o` stays low.
- R6: When the divided reference falls D cycles before the divided signal, `pump_dn_o` is high for exactly D cycles per comparison and `pump_up_o` stays low.
- R7: When both divided signals fall in the same cycle, neither `pump_up_o` nor `pump_dn_o` is asserted.
- R8: `pump_hiz_o` is 1 exactly when neither pump request is asserted. `tri_force_i`=1 holds `pump_up_o` and `pump_dn_o` at 0 and `pump_hiz_o` at 1 whatever the phase.
- R9: With `test_route_i`=0, both test pins are held at 0.
- R10: `cur_sel_o` follows `hi_cur_i` in the same cycle.
- R11: While `rst_n` is low and after it is released, `pump_up_o`=0, `pump_dn_o`=0 and `pump_hiz_o`=1. Both dividers restart from count zero, so equal ratios released together are in phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_tick_i | input | 1 | One-cycle strobe per reference-clock period |
| sig_tick_i | input | 1 | One-cycle strobe per prescaled-input period |
| ratio_i | input | 15 | Programmable divider ratio N |
| tri_force_i | input | 1 | Force pump output high-impedance |
| test_route_i | input | 1 | Route divided waveforms to test pins |
| hi_cur_i | input | 1 | Pump current select (1 = high) |
| pump_up_o | output | 1 | Request source current |
| pump_dn_o | output | 1 | Request sink current |
| pump_hiz_o | output | 1 | Pump output high-impedance |
| cur_sel_o | output | 1 | Pump current select to the pump |
| tp_sig_o | output | 1 | Divided signal on test pin |
| tp_ref_o | output | 1 | Divided reference on test pin |

## Verification
The detector is tried with three start patterns: signal strobes started five cycles ahead of the reference, the reverse, and both started together. Counting pulse cycles on each pump line therefore separates source from sink, exact width from off-by-one, and true coincidence from a spurious pulse. The same signal-leading pattern is repeated with the force bit set, to show that the pump is muted while the detector keeps running. The divider is measured at the minimum ratio, at a middle ratio, at the maximum ratio and at a clamped ratio. A mid-period ratio change separates a load at terminal count from an immediate load.

// File: rtl/synth_pll_pkg.sv
// Shared parameters for the synthesizer divider and phase detector.
// Assumes: all logic in one clock domain, inputs arrive as tick strobes.
package synth_pll_pkg;
    parameter int RATIO_W   = 15;   // programmable ratio width
    parameter int MIN_RATIO = 256;  // lowest legal ratio
    parameter int REF_RATIO = 512;  // fixed reference division

    // Pump request pair produced by the detector
    typedef struct packed {
        logic up;
        logic dn;
    } pump_req_t;
endpackage

// File: rtl/synth_ratio_div.sv
// Tick-driven divide-by-N counter. The output is high for the first N/2
// ticks and low for the rest. A one-cycle fall strobe coincides with the
// output's high-to-low step. The ratio is clamped to MIN and is sampled
// only at terminal count (and during reset).
// Assumes: tick_i is a one-cycle strobe in the clk domain.
module synth_ratio_div #(
    parameter int W   = synth_pll_pkg::RATIO_W,
    parameter int MIN = synth_pll_pkg::MIN_RATIO
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick_i,
    input  logic [W-1:0] ratio_i,
    output logic         div_o,
    output logic         fall_o
);
    localparam logic [W-1:0] MIN_V = W'(MIN);

    logic [W-1:0] active_q;
    logic [W-1:0] cnt_q;
    logic [W-1:0] ratio_c;
    logic [W-1:0] half_c;
    logic         tc_c;
    logic         fall_q;

    // Clamp request and derive half point and terminal count
    always_comb begin
        ratio_c = (ratio_i < MIN_V) ? MIN_V : ratio_i;
        half_c  = active_q >> 1;
        tc_c    = (cnt_q == active_q - 1'b1);
    end

    // Count ticks, wrap at terminal count and adopt the pending ratio there
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            active_q <= ratio_c;
            fall_q   <= 1'b0;
        end else begin
            fall_q <= tick_i && (cnt_q == half_c - 1'b1);
            if (tick_i) begin
                if (tc_c) begin
                    cnt_q    <= '0;
                    active_q <= ratio_c;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    assign div_o  = (cnt_q < half_c);
    assign fall_o = fall_q;

    // R2: count never leaves 0..N-1
    p_cnt_in_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < active_q);
    // R3: adopted ratio never below the minimum
    p_ratio_floor_r3: assert property (@(posedge clk) disable iff (!rst_n)
        active_q >= MIN_V);
    // R4: ratio does not change away from terminal count
    p_ratio_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(tick_i && tc_c) |=> $stable(active_q));
endmodule

// File: rtl/synth_pfd.sv
// Two-flag tri-state phase/frequency detector on fall strobes. Each fall
// sets its own flag. When both flags are set, both clear on the next clock.
// The outputs are masked while both are set, so coincident edges give no
// request.
// Assumes: strobes are one cycle long; a strobe in the clear cycle is lost.
module synth_pfd
    import synth_pll_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      sig_fall_i,
    input  logic      ref_fall_i,
    output pump_req_t req_o
);
    logic up_q;
    logic dn_q;

    // Set flags on edges; clear both one cycle after they meet
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            up_q <= 1'b0;
            dn_q <= 1'b0;
        end else if (up_q && dn_q) begin
            up_q <= 1'b0;
            dn_q <= 1'b0;
        end else begin
            up_q <= up_q | sig_fall_i;
            dn_q <= dn_q | ref_fall_i;
        end
    end

    // Only a lone flag is a request
    always_comb begin
        req_o.up = up_q & ~dn_q;
        req_o.dn = dn_q & ~up_q;
    end

    // R5: a lone source flag persists until the reference edge
    p_up_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (up_q && !dn_q && !ref_fall_i) |=> up_q);
    // R6: a lone sink flag persists until the signal edge
    p_dn_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_q && !up_q && !sig_fall_i) |=> dn_q);
    // R7: meeting flags always clear together
    p_flags_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (up_q && dn_q) |=> (!up_q && !dn_q));
endmodule

// File: rtl/synth_pll_core.sv
// Top of the synthesizer digital core: fixed reference divider,
// programmable signal divider, phase/frequency detector, pump gating and
// test routing.
// Assumes: single clock domain, tick strobes, synchronous active-low reset.
module synth_pll_core
    import synth_pll_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ref_tick_i,
    input  logic               sig_tick_i,
    input  logic [RATIO_W-1:0] ratio_i,
    input  logic               tri_force_i,
    input  logic               test_route_i,
    input  logic               hi_cur_i,
    output logic               pump_up_o,
    output logic               pump_dn_o,
    output logic               pump_hiz_o,
    output logic               cur_sel_o,
    output logic               tp_sig_o,
    output logic               tp_ref_o
);
    localparam logic [RATIO_W-1:0] REF_V = RATIO_W'(REF_RATIO);

    logic      ref_div, ref_fall;
    logic      sig_div, sig_fall;
    pump_req_t req;

    // Fixed reference divider
    synth_ratio_div #(.W(RATIO_W), .MIN(MIN_RATIO)) u_ref_div (
        .clk(clk), .rst_n(rst_n), .tick_i(ref_tick_i), .ratio_i(REF_V),
        .div_o(ref_div), .fall_o(ref_fall)
    );

    // Programmable signal divider
    synth_ratio_div #(.W(RATIO_W), .MIN(MIN_RATIO)) u_sig_div (
        .clk(clk), .rst_n(rst_n), .tick_i(sig_tick_i), .ratio_i(ratio_i),
        .div_o(sig_div), .fall_o(sig_fall)
    );

    // Phase/frequency detector
    synth_pfd u_pfd (
        .clk(clk), .rst_n(rst_n), .sig_fall_i(sig_fall), .ref_fall_i(ref_fall),
        .req_o(req)
    );

    // Pump gating, high-impedance flag and test routing
    always_comb begin
        pump_up_o  = req.up & ~tri_force_i;
        pump_dn_o  = req.dn & ~tri_force_i;
        pump_hiz_o = ~(pump_up_o | pump_dn_o);
        cur_sel_o  = hi_cur_i;
        tp_sig_o   = test_route_i & sig_div;
        tp_ref_o   = test_route_i & ref_div;
    end

    // R8: forced tristate mutes the pump entirely
    p_force_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        tri_force_i |-> (pump_hiz_o && !pump_up_o && !pump_dn_o));
endmodule

// File: tb/synth_pll_core_bench.sv
// Directed bench for synth_pll_core: one task per scenario.
module synth_pll_core_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ref_tick = 1'b0, sig_tick = 1'b0;
    logic [14:0] ratio = 15'd512;
    logic        t0 = 1'b0, t1 = 1'b0, hi_cur = 1'b0;
    logic        up, dn, hiz, cur_sel, tps, tpr;
    int          n_run = 0, n_fail = 0;
    bit          done = 1'b0;

    always #4 clk = ~clk; // 125 MHz

    synth_pll_core u_synth_pll_core (
        .clk(clk), .rst_n(rst_n), .ref_tick_i(ref_tick), .sig_tick_i(sig_tick),
        .ratio_i(ratio), .tri_force_i(t0), .test_route_i(t1), .hi_cur_i(hi_cur),
        .pump_up_o(up), .pump_dn_o(dn), .pump_hiz_o(hiz), .cur_sel_o(cur_sel),
        .tp_sig_o(tps), .tp_ref_o(tpr)
    );

    task automatic check(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; ref_tick = 1'b0; sig_tick = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Cycles between two falls of the chosen test pin; optional ratio change after first fall
    task automatic fall_gap(input bit use_ref, input bit chg, input logic [14:0] nr,
                            output int gap);
        logic prev, cur;
        prev = use_ref ? tpr : tps;
        gap = 0;
        for (int i = 0; i < 70000; i++) begin
            @(negedge clk);
            cur = use_ref ? tpr : tps;
            if (prev && !cur) break;
            prev = cur;
        end
        if (chg) ratio = nr;
        prev = 1'b0;
        for (int i = 0; i < 70000; i++) begin
            @(negedge clk);
            gap++;
            cur = use_ref ? tpr : tps;
            if (prev && !cur) break;
            prev = cur;
        end
    endtask

    // R11: reset state
    task automatic t_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check("R11 up in reset", up, 0);
        check("R11 dn in reset", dn, 0);
        check("R11 hiz in reset", hiz, 1);
        rst_n = 1'b1;
        @(negedge clk);
        check("R11 hiz after reset", hiz, 1);
    endtask

    // R1: reference division
    task automatic t_ref_period();
        int g;
        t1 = 1'b1; do_reset(); ref_tick = 1'b1;
        fall_gap(1'b1, 1'b0, 15'd0, g);
        check("R1 ref period", g, 512);
        ref_tick = 1'b0;
    endtask

    // R2/R3: programmable division
    task automatic t_sig_period(input logic [14:0] n, input int exp, input string req);
        int g;
        t1 = 1'b1; ratio = n; do_reset(); sig_tick = 1'b1;
        fall_gap(1'b0, 1'b0, 15'd0, g);
        check(req, g, exp);
        sig_tick = 1'b0;
    endtask

    // R4: ratio adopted at terminal count
    task automatic t_ratio_change();
        int g;
        t1 = 1'b1; ratio = 15'd300; do_reset(); sig_tick = 1'b1;
        fall_gap(1'b0, 1'b1, 15'd400, g);
        check("R4 transition gap", g, 350);
        fall_gap(1'b0, 1'b0, 15'd0, g);
        check("R4 new period", g, 400);
        sig_tick = 1'b0;
    endtask

    // R9: test pins quiet when routing off
    task automatic t_route_off();
        int hi = 0;
        t1 = 1'b0; ratio = 15'd256; do_reset(); sig_tick = 1'b1; ref_tick = 1'b1;
        for (int i = 0; i < 1100; i++) begin
            @(negedge clk);
            hi += int'(tps) + int'(tpr);
        end
        check("R9 test pins held low", hi, 0);
        sig_tick = 1'b0; ref_tick = 1'b0;
    endtask

    // R5/R6/R7/R8: phase patterns; lead>0 signal first, <0 reference first
    task automatic t_phase(input int lead, input bit force_t0, input string req,
                           input int exp_up, input int exp_dn);
        int nu = 0, nd = 0, bad = 0, nh = 0;
        t1 = 1'b0; t0 = force_t0; ratio = 15'd512; do_reset();
        if (lead >= 0) sig_tick = 1'b1; else ref_tick = 1'b1;
        for (int i = 0; i < ((lead < 0) ? -lead : lead); i++) @(negedge clk);
        sig_tick = 1'b1; ref_tick = 1'b1;
        for (int i = 0; i < 1024; i++) begin
            @(negedge clk);
            nu += int'(up); nd += int'(dn); nh += int'(hiz);
            if (hiz != !(up || dn)) bad++;
        end
        check({req, " up cycles"}, nu, exp_up);
        check({req, " dn cycles"}, nd, exp_dn);
        check("R8 hiz iff idle", bad, 0);
        if (force_t0) check("R8 forced hiz cycles", nh, 1024);
        sig_tick = 1'b0; ref_tick = 1'b0; t0 = 1'b0;
    endtask

    // R10: current select passthrough
    task automatic t_cur_sel();
        @(negedge clk); hi_cur = 1'b1; #1;
        check("R10 cur_sel high", cur_sel, 1);
        hi_cur = 1'b0; #1;
        check("R10 cur_sel low", cur_sel, 0);
    endtask

    initial begin
        t_reset();
        t_ref_period();
        t_sig_period(15'd256, 256, "R2 ratio 256");
        t_sig_period(15'd1000, 1000, "R2 ratio 1000");
        t_sig_period(15'd32767, 32767, "R2 ratio 32767");
        t_sig_period(15'd10, 256, "R3 clamp 10");
        t_ratio_change();
        t_route_off();
        t_phase(5, 1'b0, "R5 signal leads", 10, 0);
        t_phase(-5, 1'b0, "R6 reference leads", 0, 10);
        t_phase(0, 1'b0, "R7 coincident", 0, 0);
        t_phase(5, 1'b1, "R8 forced tristate", 0, 0);
        t_cur_sel();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule